// File: doc/BRIEF.md
# Programmable Multi-Channel Input Debouncer

This block cleans up 24 independent digital inputs that come from mechanical contacts or isolated field wiring and may bounce or glitch. Each raw input is first brought onto the base clock by a two-flop synchroniser. A slow sample strobe then shifts it into a short chain of three sample registers. A per-channel hysteretic decision drives the filtered output. The output changes state only after three consecutive samples agree on the new level.

The sample rate comes from a 24-bit divider value that is loaded through a write strobe. The slow clock that the divider produces is driven to a monitor pin, so its activity can be watched from outside. Every rising edge of that monitor clock is one sample instant. The total filtering delay is about three sample periods. For example, with a 20 MHz base clock a divider value of 0xC34F gives a 5 ms sample period and a debounce of roughly 15 ms.

Top module: `bounce_filter`

## Requirements
- R1: While reset is asserted and on the first clock after its release, every filtered output is 0 and the monitor clock is 0, whatever the raw inputs are.
- R2: The divider register is 24 bits wide and holds 0 after reset. With no write, the monitor clock therefore has a period of 4 base clocks.
- R3: A divider value of 0 or of 1 gives a monitor period of 4 base clocks.
- R4: A divider value N of 2 or more gives a monitor period of 2·N+2 base clocks. The monitor clock is high for N+1 base clocks and low for N+1 base clocks.
- R5: Each channel samples its synchronised input on every rising edge of the monitor clock into a three-deep chain. A filtered output that is 0 becomes 1 only when all three samples are 1.
- R6: A filtered output that is 1 becomes 0 only when all three samples are 0.
- R7: While the three samples of a channel disagree, its filtered output keeps its value. An input that alternates between successive sample instants never changes the output.
- R8: After a raw input steps to a new level and then holds it, the filtered output follows. This happens no sooner than 2·P+3 and no later than 3·P+4 base clocks after the step, where P is the monitor period.
- R9: A divider write restarts the divider count from zero on the next base clock while keeping the monitor level. The next monitor edge then comes N'+1 base clocks after the write edge (N' being the new effective half value), and the following periods use the new value.
- R10: The channels are independent: a channel's output depends only on its own raw input bit (bit i of the raw bus drives bit i of the filtered bus).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running base clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| raw_i | input | 24 | Unfiltered asynchronous input bits |
| div_val_i | input | 24 | New divider value |
| div_wr_i | input | 1 | Load strobe for the divider value, one base clock wide |
| clean_o | output | 24 | Debounced input bits |
| tick_mon_o | output | 1 | Monitor copy of the slow sample clock |

## Verification
A wrong divider count shows at the monitor pin at once: the very next period measured between two rising edges has the wrong length. A missed restart shifts the first edge after a write by a fixed number of clocks. A corrupted sample chain or a wrong decision rule shows on the filtered bus within at most three sample periods. Depending on the fault, an output follows an alternating input, leaves a steady channel stuck, or moves outside the latency window that R8 gives. Mixed random masks of steady and alternating channels expose crosstalk between lanes in the same window.

// File: rtl/dbn_pkg.sv
package dbn_pkg;
  // depth of the per-channel sample chain
  localparam int unsigned CHAIN_LEN = 3;
  // smallest divider value that is honoured as given; below it the half period is 1
  localparam int unsigned DIV_FLOOR = 2;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2
  } dbn_act_e;
endpackage

// File: rtl/dbn_rst_sync.sv
module dbn_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= 2'b00;
    else         pipe_q <= {pipe_q[0], 1'b1};
  end

  assign rst_no = pipe_q[1];
endmodule

// File: rtl/dbn_sync.sv
module dbn_sync #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/dbn_rate_gen.sv
module dbn_rate_gen #(
  parameter int unsigned DIV_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             div_wr,
  output logic             tick,
  output logic             mon
);
  localparam logic [DIV_W-1:0] FLOOR_V = DIV_W'(dbn_pkg::DIV_FLOOR);
  localparam logic [DIV_W-1:0] ONE_V   = DIV_W'(1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] half;
  logic             mon_q, mon_d;
  logic             wrap;

  always_comb begin
    half = (div_q < FLOOR_V) ? ONE_V : div_q;
    wrap = (cnt_q >= half);
  end

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    mon_d = mon_q;
    if (div_wr) begin
      div_d = div_val;
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d = '0;
      mon_d = ~mon_q;
    end else begin
      cnt_d = cnt_q + ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
      mon_q <= 1'b0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
      mon_q <= mon_d;
    end
  end

  assign tick = wrap && !mon_q && !div_wr;
  assign mon  = mon_q;

  // R4: the half-period counter never passes the active half value
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= half);

  // R9: a load restarts the count on the next clock
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (cnt_q == '0));

  // R5: every sample strobe coincides with a rising monitor edge
  a_r5_tick_rises: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> $rose(mon_q));
endmodule

// File: rtl/dbn_lane.sv
module dbn_lane #(
  parameter int unsigned STAGES = dbn_pkg::CHAIN_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic dout
);
  import dbn_pkg::*;

  logic [STAGES-1:0] chain_q, chain_d;
  logic              out_q, out_d;
  dbn_act_e          act;

  always_comb begin
    chain_d = chain_q;
    if (tick) chain_d = {chain_q[STAGES-2:0], din};
  end

  always_comb begin
    if (&chain_q)      act = ACT_SET;
    else if (~|chain_q) act = ACT_CLR;
    else               act = ACT_HOLD;
  end

  always_comb begin
    case (act)
      ACT_SET: out_d = 1'b1;
      ACT_CLR: out_d = 1'b0;
      default: out_d = out_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      out_q   <= 1'b0;
    end else begin
      chain_q <= chain_d;
      out_q   <= out_d;
    end
  end

  assign dout = out_q;

  // R5: samples move only on a strobe
  a_r5_shift_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(chain_q));

  // R5: a rising output needs a chain of ones
  a_r5_rise_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(&chain_q));

  // R6: a falling output needs a chain of zeros
  a_r6_fall_all_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q) |-> $past(~|chain_q));

  // R7: disagreeing samples keep the output
  a_r7_hold_mixed: assert property (@(posedge clk) disable iff (!rst_n)
    ((|chain_q) && !(&chain_q)) |=> $stable(out_q));
endmodule

// File: rtl/bounce_filter.sv
module bounce_filter #(
  parameter int unsigned CH    = 24,
  parameter int unsigned DIV_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CH-1:0]    raw_i,
  input  logic [DIV_W-1:0] div_val_i,
  input  logic             div_wr_i,
  output logic [CH-1:0]    clean_o,
  output logic             tick_mon_o
);
  logic          rst_n;
  logic          tick;
  logic [CH-1:0] sync_bits;

  dbn_rst_sync u_rst (
    .clk    (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  dbn_sync #(.W(CH)) u_sync (
    .clk   (clk_i),
    .rst_n (rst_n),
    .d_i   (raw_i),
    .q_o   (sync_bits)
  );

  dbn_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk     (clk_i),
    .rst_n   (rst_n),
    .div_val (div_val_i),
    .div_wr  (div_wr_i),
    .tick    (tick),
    .mon     (tick_mon_o)
  );

  for (genvar g = 0; g < CH; g++) begin : g_lane
    dbn_lane u_lane (
      .clk   (clk_i),
      .rst_n (rst_n),
      .tick  (tick),
      .din   (sync_bits[g]),
      .dout  (clean_o[g])
    );
  end

  // R1: the block leaves reset with every output low
  a_r1_reset_clear: assert property (@(posedge clk_i)
    $rose(rst_n) |-> (clean_o == '0 && !tick_mon_o));
endmodule

// File: tb/bounce_filter_test.sv
module bounce_filter_test;
  localparam int CLK_P = 10;
  localparam int CH    = 24;
  localparam int DW    = 24;
  localparam logic [CH-1:0] ONES = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CH-1:0] raw = '0;
  logic [DW-1:0] div_val = '0;
  logic          div_wr = 1'b0;
  logic [CH-1:0] clean;
  logic          mon;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  bounce_filter uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .raw_i      (raw),
    .div_val_i  (div_val),
    .div_wr_i   (div_wr),
    .clean_o    (clean),
    .tick_mon_o (mon)
  );

  function automatic int exp_period(int n);
    return (n < 2) ? 4 : 2 * n + 2;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_div(input int v);
    @(negedge clk);
    div_val = DW'(v);
    div_wr  = 1'b1;
    @(negedge clk);
    div_wr  = 1'b0;
  endtask

  task automatic wait_rise();
    logic prev;
    prev = mon;
    forever begin
      @(negedge clk);
      if (!prev && mon) break;
      prev = mon;
    end
  endtask

  task automatic wait_fall();
    logic prev;
    prev = mon;
    forever begin
      @(negedge clk);
      if (prev && !mon) break;
      prev = mon;
    end
  endtask

  task automatic measure(output int p);
    logic prev;
    wait_rise();
    p = 0;
    prev = mon;
    forever begin
      @(negedge clk);
      p++;
      if (!prev && mon) break;
      prev = mon;
    end
  endtask

  task automatic check_period(input int n, input string tag);
    int p;
    measure(p);
    check(p == exp_period(n), tag, p, exp_period(n));
  endtask

  // drive alternating values on the masked bits for cnt sample periods
  task automatic alt_run(input logic [CH-1:0] alt, input logic [CH-1:0] steady_v,
                         input logic [CH-1:0] start_v, input int cnt,
                         input logic [CH-1:0] hold_v, output bit held);
    logic [CH-1:0] a_v;
    a_v  = start_v;
    held = 1;
    for (int i = 0; i < cnt; i++) begin
      wait_fall();
      raw = (steady_v & ~alt) | (a_v & alt);
      a_v = ~a_v;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if ((clean & alt) != (hold_v & alt)) held = 0;
      end
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog timeout actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int seed_v;
    int p;
    int k;
    int first_k;
    bit held;
    logic [CH-1:0] cur;
    logic [CH-1:0] alt;
    logic [CH-1:0] tgt;
    logic [CH-1:0] expv;

    seed_v = 32'h5eed;
    void'($urandom(seed_v));

    // R1: outputs low under reset with all inputs high
    raw = ONES;
    repeat (6) @(negedge clk);
    check(clean == '0, "R1 clean in reset", clean, 0);
    check(mon == 1'b0, "R1 monitor in reset", mon, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(clean == '0, "R1 clean after release", clean, 0);
    raw = '0;
    repeat (40) @(negedge clk);

    // R2: divider resets to zero, period 4
    check_period(0, "R2 default period");

    // R3: values 0 and 1 floor at 4
    write_div(1);
    check_period(1, "R3 div=1 period");
    write_div(0);
    check_period(0, "R3 div=0 period");

    // R4: larger values, directed then random
    write_div(2);
    check_period(2, "R4 div=2 period");
    write_div(7);
    check_period(7, "R4 div=7 period");
    for (int t = 0; t < 4; t++) begin
      int n;
      n = 2 + int'($urandom_range(38));
      write_div(n);
      check_period(n, "R4 random div period");
    end

    // R5/R8: rising latency with P=8
    write_div(3);
    p = exp_period(3);
    raw = '0;
    repeat (5 * p) @(negedge clk);
    raw = ONES;
    k = 0;
    first_k = -1;
    while (clean != ONES && k < 10 * p) begin
      @(negedge clk);
      k++;
      if (clean != '0 && first_k < 0) first_k = k;
    end
    check(clean == ONES, "R5 all ones after steady high", clean, ONES);
    check(first_k >= 2 * p + 3, "R8 rise not too early", first_k, 2 * p + 3);
    check(k <= 3 * p + 4, "R8 rise not too late", k, 3 * p + 4);

    // R6/R8: falling latency
    repeat (2 * p) @(negedge clk);
    raw = '0;
    k = 0;
    first_k = -1;
    while (clean != '0 && k < 10 * p) begin
      @(negedge clk);
      k++;
      if (clean != ONES && first_k < 0) first_k = k;
    end
    check(clean == '0, "R6 all zeros after steady low", clean, 0);
    check(first_k >= 2 * p + 3, "R8 fall not too early", first_k, 2 * p + 3);
    check(k <= 3 * p + 4, "R8 fall not too late", k, 3 * p + 4);

    // R5: a single-period pulse of one is too short to set
    write_div(5);
    p = exp_period(5);
    repeat (4 * p) @(negedge clk);
    wait_fall();
    raw = ONES;
    wait_fall();
    raw = '0;
    held = 1;
    for (int i = 0; i < 5 * p; i++) begin
      @(negedge clk);
      if (clean != '0) held = 0;
    end
    check(held, "R5 one high sample does not set", clean, 0);

    // R7: alternating input keeps a high output
    raw = ONES;
    repeat (5 * p) @(negedge clk);
    check(clean == ONES, "R5 setup high", clean, ONES);
    alt_run(ONES, ONES, '0, 8, ONES, held);
    check(held, "R7 alternating keeps high", clean, ONES);
    raw = '0;
    repeat (5 * p) @(negedge clk);
    check(clean == '0, "R6 setup low", clean, 0);
    alt_run(ONES, '0, ONES, 8, '0, held);
    check(held, "R7 alternating keeps low", clean, 0);
    raw = '0;
    repeat (5 * p) @(negedge clk);

    // R10: random mixes of steady and alternating channels
    cur = '0;
    for (int t = 0; t < 6; t++) begin
      alt = CH'($urandom);
      tgt = CH'($urandom);
      expv = (tgt & ~alt) | (cur & alt);
      alt_run(alt, tgt, ~cur, 10, cur, held);
      check(held, "R10 alternating lanes hold", clean & alt, cur & alt);
      check(clean == expv, "R10 mixed lanes", clean, expv);
      raw = expv;
      repeat (5 * p) @(negedge clk);
      check(clean == expv, "R10 settled lanes", clean, expv);
      cur = expv;
    end

    // R9: a load restarts the count mid half-period
    write_div(9);
    wait_fall();
    @(negedge clk);
    @(negedge clk);
    div_val = DW'(5);
    div_wr  = 1'b1;
    k = 0;
    forever begin
      @(negedge clk);
      k++;
      if (k == 1) div_wr = 1'b0;
      if (mon || k > 40) break;
    end
    check(k == 7, "R9 first edge after load", k, 7);
    check_period(5, "R9 period after load");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule